// File: doc/BRIEF.md
# Ripple-Through Strobe FIFO

This block is a first-in first-out buffer of 64 words of 4 bits in which every storage cell pushes its word one place toward the output whenever the next cell is free. Words therefore gather at the output end, and free slots drift back to the input end. No read or write pointer exists: position in the chain is the order.

A producer writes with a pulse handshake. While `in_rdy` is high it raises `shift_in`, which captures `din` into the head cell and drops `in_rdy`. The word stays parked in the head cell until `shift_in` falls, and only then does it start to move. A consumer reads the same way. While `out_rdy` is high it raises `shift_out`, which drops `out_rdy` while `dout` holds the word. When `shift_out` falls, the word is consumed and the next buffered word moves into the output stage. The model is synchronous to one clock. Both strobes are sampled as levels, and their edges are found inside the block. A synchronous active-low `flush_n` empties the chain. An occupancy count and full/empty flags report the fill level.

Top module: `ft_fifo`

## Requirements
- R1: While `flush_n` is low at a clock edge, the block empties: after that edge `occ`=0, `empty`=1, `full`=0, `out_rdy`=0 and `in_rdy`=1.
- R2: With `in_rdy` high, a rising `shift_in` captures `din` on the second clock edge after the rise. From that edge `in_rdy` is low and `occ` is one higher.
- R3: `in_rdy` stays low while `shift_in` stays high. After `shift_in` falls, `in_rdy` returns high on the second edge if the next cell is free.
- R4: A word advances at most one cell per clock. A word written into an empty buffer raises `out_rdy` on the 64th edge after `shift_in` falls, with that word on `dout`.
- R5: Words leave in the order they were written, under any strobe widths and gaps.
- R6: With `out_rdy` high, a rising `shift_out` drops `out_rdy` on the second edge. `dout` stays unchanged while `shift_out` is high.
- R7: After `shift_out` falls, `occ` drops by one on the second edge. If another word is buffered, it appears on `dout` with `out_rdy` high on the third edge.
- R8: While `out_rdy` is low, `dout` keeps its last value. When the buffer is empty, `out_rdy` stays low.
- R9: With 64 words held, `full` is 1 and `in_rdy` stays low after `shift_in` falls.
- R10: A rising `shift_in` while `in_rdy` is low, or a rising `shift_out` while `out_rdy` is low, changes neither `occ` nor the stored words.
- R11: `occ` equals the number of words held, never exceeds 64, and changes by at most one per clock. `full` is 1 exactly at 64 words and `empty` is 1 exactly at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| flush_n | input | 1 | Synchronous active-low clear of all cells |
| shift_in | input | 1 | Write strobe, level sampled |
| din | input | W (4) | Write data |
| in_rdy | output | 1 | Head cell free and not held |
| shift_out | input | 1 | Read strobe, level sampled |
| dout | output | W (4) | Output stage word |
| out_rdy | output | 1 | Valid word in output stage, not yet taken |
| occ | output | CW (7) | Words held, 0 to DEPTH |
| full | output | 1 | occ equals DEPTH |
| empty | output | 1 | occ equals 0 |

## Verification
Each strobe passes through two sampling registers. This makes `in_rdy` and `out_rdy` respond on the second edge after a strobe rises. The release of the head cell and the consumption of the output word land on the second edge after the strobe falls, and a refill of the output stage lands on the third. A lone word needs 64 edges from the falling `shift_in` to reach the output. The bench drives inputs on falling clock edges and counts rising edges exactly. It samples one edge before each due point, to see the old value, and again at the due point. Phases that only check data order wait on the ready flags with a bounded poll.

// File: rtl/ft_pkg.sv
package ft_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } strobe_ev_t;
endpackage

// File: rtl/ft_strobe_edge.sv
module ft_strobe_edge
  import ft_pkg::*;
(
  input  logic       clk,
  input  logic       flush_n,
  input  logic       strobe,
  output strobe_ev_t ev
);
  logic smp_q, smp_qq;

  always_ff @(posedge clk) begin
    if (!flush_n) begin
      smp_q  <= 1'b0;
      smp_qq <= 1'b0;
    end else begin
      smp_q  <= strobe;
      smp_qq <= smp_q;
    end
  end

  assign ev.rise = smp_q & ~smp_qq;
  assign ev.fall = ~smp_q & smp_qq;
endmodule

// File: rtl/ft_cell_chain.sv
module ft_cell_chain #(
  parameter int DEPTH = 64,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         flush_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         hold_head,
  input  logic         consume,
  output logic         head_valid,
  output logic         tail_valid,
  output logic [W-1:0] tail_data
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] cell_v;
  logic [DEPTH-1:0] adv;
  logic [W-1:0]     cell_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic         fill;
    logic [W-1:0] src;
    logic         v_q;
    logic [W-1:0] d_q;

    if (i == 0) begin : g_src_head
      assign fill = load;
      assign src  = load_data;
    end else begin : g_src_body
      assign fill = adv[i-1];
      assign src  = cell_d[i-1];
    end

    if (i == LAST) begin : g_adv_tail
      assign adv[i] = consume;
    end else if (i == 0) begin : g_adv_head
      assign adv[i] = v_q & ~cell_v[i+1] & ~hold_head;
    end else begin : g_adv_body
      assign adv[i] = v_q & ~cell_v[i+1];
    end

    always_ff @(posedge clk) begin
      if (!flush_n) v_q <= 1'b0;
      else          v_q <= (v_q & ~adv[i]) | fill;
    end

    always_ff @(posedge clk) begin
      if (fill) d_q <= src;
    end

    assign cell_v[i] = v_q;
    assign cell_d[i] = d_q;
  end

  assign head_valid = cell_v[0];
  assign tail_valid = cell_v[LAST];
  assign tail_data  = cell_d[LAST];
endmodule

// File: rtl/ft_occ_count.sv
module ft_occ_count #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          flush_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] TOP = CW'(DEPTH);

  logic [CW-1:0] cnt_nx;

  always_comb begin
    unique case ({inc, dec})
      2'b10:   cnt_nx = cnt + 1'b1;
      2'b01:   cnt_nx = cnt - 1'b1;
      default: cnt_nx = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!flush_n) begin
      cnt   <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      cnt   <= cnt_nx;
      full  <= (cnt_nx == TOP);
      empty <= (cnt_nx == '0);
    end
  end
endmodule

// File: rtl/ft_fifo.sv
module ft_fifo
  import ft_pkg::*;
#(
  parameter int  DEPTH = 64,
  parameter int  W     = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          flush_n,
  input  logic          shift_in,
  input  logic [W-1:0]  din,
  output logic          in_rdy,
  input  logic          shift_out,
  output logic [W-1:0]  dout,
  output logic          out_rdy,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);
  strobe_ev_t   wr_ev, rd_ev;
  logic [W-1:0] din_q;
  logic         in_hold, out_hold;
  logic         head_valid, tail_valid;
  logic         capture, take;

  ft_strobe_edge u_wr_edge (
    .clk(clk), .flush_n(flush_n), .strobe(shift_in), .ev(wr_ev)
  );

  ft_strobe_edge u_rd_edge (
    .clk(clk), .flush_n(flush_n), .strobe(shift_out), .ev(rd_ev)
  );

  always_ff @(posedge clk) begin
    din_q <= din;
  end

  assign in_rdy  = ~head_valid & ~in_hold;
  assign out_rdy = tail_valid & ~out_hold;
  assign capture = wr_ev.rise & in_rdy;
  assign take    = rd_ev.fall & out_hold;

  always_ff @(posedge clk) begin
    if (!flush_n) begin
      in_hold  <= 1'b0;
      out_hold <= 1'b0;
    end else begin
      if (capture)         in_hold <= 1'b1;
      else if (wr_ev.fall) in_hold <= 1'b0;
      if (rd_ev.rise && out_rdy) out_hold <= 1'b1;
      else if (rd_ev.fall)       out_hold <= 1'b0;
    end
  end

  ft_cell_chain #(.DEPTH(DEPTH), .W(W)) u_chain (
    .clk(clk),
    .flush_n(flush_n),
    .load(capture),
    .load_data(din_q),
    .hold_head(in_hold & ~wr_ev.fall),
    .consume(take),
    .head_valid(head_valid),
    .tail_valid(tail_valid),
    .tail_data(dout)
  );

  ft_occ_count #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk(clk),
    .flush_n(flush_n),
    .inc(capture),
    .dec(take),
    .cnt(occ),
    .full(full),
    .empty(empty)
  );
endmodule

// File: rtl/ft_fifo_chk.sv
module ft_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int W     = 4,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          flush_n,
  input logic          in_rdy,
  input logic          out_rdy,
  input logic [W-1:0]  dout,
  input logic [CW-1:0] occ,
  input logic          full,
  input logic          empty
);
  logic seen;
  always_ff @(posedge clk) seen <= flush_n;

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!flush_n)
    occ <= CW'(DEPTH)); // R11
  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!flush_n)
    seen |-> (occ == $past(occ)) || (occ == $past(occ) + 1'b1) || (occ + 1'b1 == $past(occ))); // R11
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!flush_n)
    full |-> !in_rdy); // R9
  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!flush_n)
    empty |-> !out_rdy); // R8
  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!flush_n)
    !out_rdy |=> (out_rdy || $stable(dout))); // R8
  AST_CAPTURE_COUNTS: assert property (@(posedge clk) disable iff (!flush_n)
    (seen && $fell(in_rdy)) |-> (occ == $past(occ) + 1'b1) || (occ == $past(occ))); // R2
endmodule

bind ft_fifo ft_fifo_chk #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_chk (
  .clk(clk), .flush_n(flush_n), .in_rdy(in_rdy), .out_rdy(out_rdy),
  .dout(dout), .occ(occ), .full(full), .empty(empty)
);

// File: tb/ft_fifo_tb.sv
module ft_fifo_tb;
  localparam int DEPTH = 64;
  localparam int W     = 4;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NVEC  = 12;
  // each entry: data in [7:4], idle gap in [3:0]
  localparam logic [7:0] VEC [NVEC] = '{8'hA0, 8'h53, 8'hF1, 8'h05, 8'h32, 8'hC4,
                                        8'h60, 8'h97, 8'h12, 8'hE0, 8'h7B, 8'h26};

  logic clk = 1'b0;
  logic flush_n, shift_in, shift_out;
  logic [W-1:0] din, dout;
  logic in_rdy, out_rdy, full, empty;
  logic [CW-1:0] occ;
  int checks = 0;
  int errors = 0;
  logic [W-1:0] mq [$];

  always #5 clk = ~clk;

  ft_fifo #(.DEPTH(DEPTH), .W(W)) u_dut (
    .clk(clk), .flush_n(flush_n), .shift_in(shift_in), .din(din), .in_rdy(in_rdy),
    .shift_out(shift_out), .dout(dout), .out_rdy(out_rdy), .occ(occ),
    .full(full), .empty(empty)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_flag(input string req, input bit which);
    for (int k = 0; k < 400; k++) begin
      if ((which ? out_rdy : in_rdy) == 1'b1) return;
      tick(1);
    end
    check(req, 0, 1);
  endtask

  task automatic push(input logic [W-1:0] d, input int width);
    wait_flag("R3 in_rdy timeout", 1'b0);
    din = d;
    shift_in = 1'b1;
    tick(2 + width);
    shift_in = 1'b0;
    tick(2);
  endtask

  task automatic pop(input string req, input logic [W-1:0] exp, input int width);
    logic [W-1:0] got;
    wait_flag("R7 out_rdy timeout", 1'b1);
    got = dout;
    check(req, int'(got), int'(exp));
    shift_out = 1'b1;
    tick(2 + width);
    check("R6 dout held while shift_out high", int'(dout), int'(got));
    shift_out = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    flush_n = 1'b0; shift_in = 1'b0; shift_out = 1'b0; din = '0;
    tick(3);
    check("R1 occ", int'(occ), 0);
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 out_rdy", int'(out_rdy), 0);
    check("R1 in_rdy", int'(in_rdy), 1);
    flush_n = 1'b1;
    tick(2);

    // directed latency through an empty buffer
    din = 4'h5; shift_in = 1'b1;
    tick(1);
    check("R2 in_rdy before capture", int'(in_rdy), 1);
    check("R2 occ before capture", int'(occ), 0);
    tick(1);
    check("R2 in_rdy after capture", int'(in_rdy), 0);
    check("R2 occ after capture", int'(occ), 1);
    tick(3);
    check("R3 in_rdy held", int'(in_rdy), 0);
    shift_in = 1'b0;
    tick(1);
    check("R3 in_rdy one edge after fall", int'(in_rdy), 0);
    tick(1);
    check("R3 in_rdy two edges after fall", int'(in_rdy), 1);
    tick(61);
    check("R4 out_rdy at edge 63", int'(out_rdy), 0);
    tick(1);
    check("R4 out_rdy at edge 64", int'(out_rdy), 1);
    check("R4 dout", int'(dout), 5);
    shift_out = 1'b1;
    tick(1);
    check("R6 out_rdy one edge", int'(out_rdy), 1);
    tick(1);
    check("R6 out_rdy two edges", int'(out_rdy), 0);
    tick(3);
    check("R6 dout stable", int'(dout), 5);
    shift_out = 1'b0;
    tick(1);
    check("R7 occ one edge after fall", int'(occ), 1);
    tick(1);
    check("R7 occ two edges after fall", int'(occ), 0);
    check("R11 empty", int'(empty), 1);
    tick(5);
    check("R8 out_rdy empty", int'(out_rdy), 0);
    check("R8 dout kept", int'(dout), 5);
    shift_out = 1'b1; tick(3); shift_out = 1'b0; tick(3);
    check("R10 ignored read occ", int'(occ), 0);
    check("R10 ignored read dout", int'(dout), 5);
    push(4'h9, 0);
    pop("R10 word after ignored read", 4'h9, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      push(VEC[i][7:4], 0);
      tick(int'(VEC[i][3:0]));
      check("R11 occ after write", int'(occ), i + 1);
    end
    for (int i = 0; i < NVEC; i++) pop("R5 table order", VEC[i][7:4], i % 3);
    tick(3);
    check("R11 empty after drain", int'(empty), 1);

    // fill to capacity
    for (int i = 0; i < DEPTH; i++) push(W'(i), 0);
    tick(2);
    check("R9 full", int'(full), 1);
    check("R9 in_rdy", int'(in_rdy), 0);
    check("R11 occ full", int'(occ), DEPTH);
    din = 4'hF; shift_in = 1'b1; tick(3); shift_in = 1'b0; tick(3);
    check("R10 ignored write occ", int'(occ), DEPTH);
    check("R4 out_rdy full", int'(out_rdy), 1);
    check("R5 first out", int'(dout), 0);
    shift_out = 1'b1; tick(2);
    check("R6 out_rdy low", int'(out_rdy), 0);
    shift_out = 1'b0; tick(2);
    check("R7 occ after take", int'(occ), DEPTH - 1);
    check("R7 out_rdy gap", int'(out_rdy), 0);
    tick(1);
    check("R7 refill out_rdy", int'(out_rdy), 1);
    check("R7 refill dout", int'(dout), 1);
    for (int i = 1; i < DEPTH; i++) pop("R5 fill order", W'(i), 0);

    // random strobe timing
    for (int it = 0; it < 120; it++) begin
      if (mq.size() == 0 || (mq.size() < DEPTH && $urandom_range(0, 2) != 0)) begin
        logic [W-1:0] d;
        d = W'($urandom_range(0, 15));
        mq.push_back(d);
        push(d, $urandom_range(0, 4));
      end else begin
        pop("R5 random order", mq.pop_front(), $urandom_range(0, 4));
      end
      tick($urandom_range(0, 5));
    end
    while (mq.size() > 0) pop("R5 random drain", mq.pop_front(), 1);

    // reset in mid operation
    push(4'h3, 0); push(4'h4, 0); push(4'h6, 0);
    flush_n = 1'b0;
    tick(1);
    check("R1 occ mid", int'(occ), 0);
    check("R1 empty mid", int'(empty), 1);
    check("R1 out_rdy mid", int'(out_rdy), 0);
    check("R1 in_rdy mid", int'(in_rdy), 1);
    flush_n = 1'b1;
    tick(80);
    check("R1 stays empty", int'(out_rdy), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule